// File: doc/BRIEF.md
# Pin Bank Controller with Interrupt Detection

This block controls a bank of general-purpose pins, one bit per pin in every register, with 32 pins by default. Software reaches it over a simple word-addressed register bus. It can drive any pin as an output. It samples every pin through a two-flop synchronizer, and the sampled level can be read back at any time. Each pin can also be watched for a rising edge, a falling edge, a low level or a high level.

Every writable register can be written whole, or through three alias addresses that set, clear or invert only the bits written as one. Detected events are kept in a status register. A status bit can be removed only through the clear alias of that register. The status bits that are also enabled are merged into one interrupt line for the whole bank.

Top module: `pin_bank_ctrl`

## Requirements
- R1: `bus_addr[4:2]` selects the register: 0 drive data, 1 sampled input, 2 drive enable, 3 interrupt routing, 4 interrupt enable, 5 level select, 6 polarity, 7 event status. `bus_addr[1:0]` selects the access kind: 0 plain write, 1 set, 2 clear, 3 toggle. A read through any of the four access kinds returns the register's value on `bus_rdata` in the same cycle.
- R2: On a writable register, a plain write replaces the value. The set, clear and toggle kinds change only the bits that are one in `bus_wdata`.
- R3: The sampled input register shows `pin_in` after two rising clock edges. Writes to it have no effect.
- R4: `pad_oe` equals the drive enable register. `pad_out` carries a drive data bit only where the enable bit is 1, and is 0 elsewhere.
- R5: Each pin's detection type is {polarity, level select}: 00 falling edge, 01 low level, 10 rising edge, 11 high level. An edge on `pin_in` sets the status bit at the third rising clock edge after the change.
- R6: In a level mode the status bit is set on every cycle in which the active level is sampled. A clear issued while the level persists therefore leaves the bit set.
- R7: Status bits stay set until written as one through the clear alias. Plain, set and toggle writes to the status register change nothing.
- R8: A status bit is set only for a pin whose routing bit is 1.
- R9: `irq` is high exactly when some status bit and its interrupt enable bit are both 1.
- R10: When a detection and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R11: After reset every register reads zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Word address: register in [4:2], access kind in [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| pin_in | input | 32 | Pin levels (asynchronous) |
| pad_out | output | 32 | Output levels, gated by the drive enable |
| pad_oe | output | 32 | Drive enable per pin |
| irq | output | 1 | Combined bank interrupt |

## Verification
A detection on a pin and a software clear of that pin's status bit can occur on the same clock edge. The bench provokes this by changing a pin in rising-edge mode and then timing a clear-alias write so that it takes effect on the third edge after the change, which is the edge where the detection lands. It passes only if the bit reads set afterwards. A control case, where the same clear is issued with no detection pending, must leave the bit cleared. The same race arises in level mode while the level is held, and the bench checks that case as well.

// File: rtl/pbk_pkg.sv
package pbk_pkg;
  localparam int REG_IDX_W = 3;
  localparam int KIND_W    = 2;

  typedef enum logic [REG_IDX_W-1:0] {
    RG_DOUT  = 3'd0,
    RG_DIN   = 3'd1,
    RG_OE    = 3'd2,
    RG_ROUTE = 3'd3,
    RG_IEN   = 3'd4,
    RG_LVL   = 3'd5,
    RG_POL   = 3'd6,
    RG_STAT  = 3'd7
  } reg_sel_e;

  typedef enum logic [KIND_W-1:0] {
    AK_WRITE = 2'd0,
    AK_SET   = 2'd1,
    AK_CLR   = 2'd2,
    AK_TGL   = 2'd3
  } access_kind_e;
endpackage

// File: rtl/pbk_sync.sv
module pbk_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pbk_cfg_reg.sv
module pbk_cfg_reg
  import pbk_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [KIND_W-1:0] kind,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      q
);
  function automatic logic [W-1:0] apply_kind(input logic [W-1:0] cur,
                                               input logic [W-1:0] val,
                                               input logic [KIND_W-1:0] k);
    case (k)
      AK_SET:  return cur | val;
      AK_CLR:  return cur & ~val;
      AK_TGL:  return cur ^ val;
      default: return val;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (wr_hit) q <= apply_kind(q, wdata, kind);
  end

  // R2: a set access leaves every written one bit at 1
  p_set_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && kind == AK_SET) |=> ((q & $past(wdata)) == $past(wdata)));
  // R2: a clear access leaves every written one bit at 0
  p_clr_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && kind == AK_CLR) |=> ((q & $past(wdata)) == '0));
endmodule

// File: rtl/pbk_detect.sv
module pbk_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] route,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] evt,
  output logic [W-1:0] stat
);
  logic [W-1:0] prev;

  // A pin hits when its sample matches the polarity; in edge mode it must
  // also differ from the previous sample.
  function automatic logic [W-1:0] hit_vec(input logic [W-1:0] s,
                                           input logic [W-1:0] p,
                                           input logic [W-1:0] lv,
                                           input logic [W-1:0] pl);
    logic [W-1:0] match;
    match = ~(s ^ pl);
    return match & (lv | (s ^ p));
  endfunction

  assign evt = hit_vec(smp, prev, lvl, pol) & route;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      stat <= '0;
    end else begin
      prev <= smp;
      stat <= (stat & ~clr_mask) | evt;
    end
  end

  // R7: a status bit only drops where a clear was requested
  p_stat_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat) & ~stat & ~$past(clr_mask)) == '0));
  // R8: newly set status bits belong to routed pins
  p_route_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((stat & ~$past(stat)) & ~$past(route)) == '0));
  // R10: a detection in the same cycle as a clear still sets the bit
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & clr_mask) != '0) |=> ((stat & $past(evt)) == $past(evt)));
endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pbk_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic [REG_IDX_W+KIND_W-1:0] bus_addr,
  input  logic [PINS-1:0]             bus_wdata,
  output logic [PINS-1:0]             bus_rdata,
  input  logic [PINS-1:0]             pin_in,
  output logic [PINS-1:0]             pad_out,
  output logic [PINS-1:0]             pad_oe,
  output logic                        irq
);
  localparam int NREG = 1 << REG_IDX_W;

  logic [REG_IDX_W-1:0] reg_sel;
  logic [KIND_W-1:0]    kind;
  logic [PINS-1:0]      regs [NREG];
  logic [PINS-1:0]      smp, evt, stat, clr_mask;

  assign reg_sel = bus_addr[REG_IDX_W+KIND_W-1:KIND_W];
  assign kind    = bus_addr[KIND_W-1:0];

  pbk_sync #(.W(PINS)) u_sync (.clk(clk), .rst_n(rst_n), .d(pin_in), .q(smp));

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == int'(RG_DIN)) begin : g_din
      assign regs[g] = smp;
    end else if (g == int'(RG_STAT)) begin : g_stat
      assign regs[g] = stat;
    end else begin : g_cfg
      pbk_cfg_reg #(.W(PINS)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_hit(bus_wr && reg_sel == REG_IDX_W'(g)),
        .kind(kind), .wdata(bus_wdata), .q(regs[g]));
    end
  end

  assign clr_mask = (bus_wr && reg_sel == RG_STAT && kind == AK_CLR)
                    ? bus_wdata : '0;

  pbk_detect #(.W(PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .smp(smp),
    .lvl(regs[RG_LVL]), .pol(regs[RG_POL]), .route(regs[RG_ROUTE]),
    .clr_mask(clr_mask), .evt(evt), .stat(stat));

  assign bus_rdata = regs[reg_sel];
  assign pad_oe    = regs[RG_OE];
  assign pad_out   = regs[RG_DOUT] & regs[RG_OE];
  assign irq       = |(stat & regs[RG_IEN]);

  // R9: the bank interrupt always has an enabled status bit behind it
  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((stat & regs[RG_IEN]) != '0));
  // R3: the sampled input register ignores writes and follows the pins
  p_din_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && reg_sel == RG_DIN) |=> (regs[RG_DIN] == $past(u_sync.meta)));
endmodule

// File: tb/sim_pin_bank_ctrl.sv
module sim_pin_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  localparam logic [2:0] DOUT = 0, DIN = 1, OE = 2, ROUTE = 3, IEN = 4,
                         LVL = 5, POL = 6, STAT = 7;
  localparam logic [1:0] WR = 0, SETK = 1, CLRK = 2, TGLK = 3;

  pin_bank_ctrl u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  always #5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] r, input logic [1:0] k,
                    input logic [31:0] d);
    bus_addr = {r, k}; bus_wdata = d; bus_wr = 1'b1;
    tick(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] r, input logic [1:0] k,
                    output logic [31:0] d);
    bus_addr = {r, k}; #1; d = bus_rdata;
  endtask

  task automatic quiet();
    wr(ROUTE, WR, 0); wr(IEN, WR, 0); wr(LVL, WR, 0); wr(POL, WR, 0);
    pin_in = '0; tick(4);
    wr(STAT, CLRK, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int r = 0; r < 8; r++) begin
      rd(3'(r), WR, v); check("R11 reset value", v, 0);
    end
    check("R11 irq after reset", {31'd0, irq}, 0);
    check("R11 pad_oe after reset", pad_oe, 0);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    wr(OE, WR, 32'h0000_00F0); rd(OE, WR, v); check("R2 plain write", v, 32'hF0);
    wr(OE, SETK, 32'h0F);      rd(OE, WR, v); check("R2 set kind", v, 32'hFF);
    wr(OE, CLRK, 32'h30);      rd(OE, WR, v); check("R2 clear kind", v, 32'hCF);
    wr(OE, TGLK, 32'h101);     rd(OE, WR, v); check("R2 toggle kind", v, 32'h1CE);
    rd(OE, SETK, v); check("R1 read via set alias", v, 32'h1CE);
    rd(OE, TGLK, v); check("R1 read via toggle alias", v, 32'h1CE);
    wr(OE, WR, 0);
  endtask

  task automatic t_din();
    logic [31:0] v;
    pin_in = 32'hA5A5_0001; tick(1);
    rd(DIN, WR, v); check("R3 not yet sampled", v, 0);
    tick(1);
    rd(DIN, WR, v); check("R3 sampled after two edges", v, 32'hA5A5_0001);
    wr(DIN, WR, 32'hFFFF_FFFF); rd(DIN, WR, v); check("R3 write ignored", v, 32'hA5A5_0001);
    pin_in = '0; tick(3);
  endtask

  task automatic t_pad();
    wr(DOUT, WR, 32'hFFFF_0000); wr(OE, WR, 32'h00FF_FF00);
    check("R4 pad_out gated", pad_out, 32'h00FF_0000);
    check("R4 pad_oe", pad_oe, 32'h00FF_FF00);
    wr(DOUT, WR, 0); wr(OE, WR, 0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    quiet();
    wr(POL, WR, 32'h1); wr(ROUTE, WR, 32'h3);   // pin0 rising, pin1 falling
    pin_in = 32'h1; tick(2);
    rd(STAT, WR, v); check("R5 rising not before third edge", v, 0);
    tick(1);
    rd(STAT, WR, v); check("R5 rising edge sets", v, 32'h1);
    pin_in = 32'h3; tick(3);
    rd(STAT, WR, v); check("R5 rise ignored in falling mode", v, 32'h1);
    pin_in = 32'h1; tick(3);
    rd(STAT, WR, v); check("R5 falling edge sets", v, 32'h3);
    tick(3);
    rd(STAT, WR, v); check("R7 edge status sticky", v, 32'h3);
    wr(STAT, WR, 0);     rd(STAT, WR, v); check("R7 plain write ignored", v, 32'h3);
    wr(STAT, TGLK, 3);   rd(STAT, WR, v); check("R7 toggle ignored", v, 32'h3);
    wr(STAT, SETK, 32'h10); rd(STAT, WR, v); check("R7 set ignored", v, 32'h3);
    wr(STAT, CLRK, 32'h1); rd(STAT, WR, v); check("R7 clear kind clears", v, 32'h2);
  endtask

  task automatic t_level();
    logic [31:0] v;
    quiet();
    wr(LVL, WR, 32'h3); wr(POL, WR, 32'h2); wr(ROUTE, WR, 32'h3); // pin0 low, pin1 high
    tick(1);
    rd(STAT, WR, v); check("R6 low level sets", v, 32'h1);
    wr(STAT, CLRK, 32'h1); rd(STAT, WR, v); check("R6 clear during level", v, 32'h1);
    pin_in = 32'h2; tick(3);
    rd(STAT, WR, v); check("R6 high level sets", v, 32'h3);
    pin_in = 32'h1; tick(3);
    wr(STAT, CLRK, 32'h3); rd(STAT, WR, v); check("R6 clear after level gone", v, 0);
  endtask

  task automatic t_route_irq();
    logic [31:0] v;
    quiet();
    wr(POL, WR, 32'hFFFF_FFFF); wr(ROUTE, WR, 32'h100);
    pin_in = 32'h300; tick(3);
    rd(STAT, WR, v); check("R8 only routed pin", v, 32'h100);
    check("R9 no enable no irq", {31'd0, irq}, 0);
    wr(IEN, WR, 32'h200); check("R9 other enable no irq", {31'd0, irq}, 0);
    wr(IEN, SETK, 32'h100); check("R9 enabled status irq", {31'd0, irq}, 1);
    wr(STAT, CLRK, 32'h100); check("R9 irq drops on clear", {31'd0, irq}, 0);
  endtask

  task automatic t_race();
    logic [31:0] v;
    quiet();
    wr(POL, WR, 32'h10); wr(ROUTE, WR, 32'h10);
    pin_in = 32'h10; tick(3);
    pin_in = 32'h0;  tick(3);
    wr(STAT, CLRK, 32'h10); rd(STAT, WR, v); check("R10 control clear", v, 0);
    pin_in = 32'h10; tick(3);
    pin_in = 32'h0;  tick(3);
    pin_in = 32'h10; tick(2);
    wr(STAT, CLRK, 32'h10);   // lands on the detection edge
    rd(STAT, WR, v); check("R10 set wins over clear", v, 32'h10);
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_alias();
    t_din();
    t_pad();
    t_edge();
    t_level();
    t_route_irq();
    t_race();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule